// File: doc/BRIEF.md
# Private Line Detector

This block sits beside a shared second-level cache and keeps a small record for every line, from which it decides whether the line is private, that is, touched by a single core only. Such a line may safely live in that core's first-level cache without any coherence protocol. The record holds the core that touched the line first, a sticky flag for sharing by a second core, a maturity counter, and a flag that says a first-level copy was granted.

The cache controller reports fills, evictions and accesses, each with a line index and the requesting core. On an access, the block returns whether the requester may cache the line. When another core touches a line whose copy was granted, the block issues one invalidate naming the recorded owner, and the line stays shared until it is evicted or refilled. Maturity is measured in epochs: a global tick, pulsed every N cycles by the surrounding logic, ages every resident line. Because of this, a line becomes cacheable only after at least N cycles without sharing.

Top module: `private_line_detector`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, rsp_valid, rsp_cacheable and inv_valid are low.
- R2: An access (req_op 0) to a line that is not resident produces a response with rsp_cacheable low, changes no state, and records no owner.
- R3: The first access after a fill (req_op 1) stores the requester as owner. Later accesses by that core are treated as owner accesses.
- R4: rsp_cacheable is high only for the owner (or the first accessor), only while the sharing flag is clear, and only once the maturity count is zero. A fill loads the count with MAT_LOAD (default 2). Each epoch tick lowers the count by one and stops at zero. The first access grants the cached state.
- R5: An access by a core other than the owner sets the sharing flag. The flag stays set, and the line is never reported cacheable, until an eviction or a fill of that line.
- R6: An access by a non-owner to a line whose copy was granted makes inv_valid high for one cycle, with inv_core equal to the owner and rsp_cacheable low. The grant is then withdrawn.
- R7: A non-owner access to a line with no granted copy raises no invalidate.
- R8: An eviction (req_op 2) clears the owner, the sharing flag, the grant and the count. After a later fill, a new owner is recorded.
- R9: A fill that coincides with an epoch tick loads the full count, so the tick does not apply to that line. An access decides on the count held before a tick that arrives in the same cycle.
- R10: Outputs are registered. A request sampled at a clock edge shows its response after that edge, for one cycle. Fills, evictions, req_op 3 and idle cycles give rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| epoch_tick | input | 1 | One-cycle pulse every N cycles; ages all resident lines |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 access, 1 fill, 2 evict, 3 no operation |
| req_line | input | LINE_W | Line index |
| req_core | input | CORE_W | Requesting core |
| rsp_valid | output | 1 | Response to an access |
| rsp_cacheable | output | 1 | Requester may hold the line in its private cache |
| inv_valid | output | 1 | Invalidate request pulse |
| inv_core | output | CORE_W | Core to invalidate (recorded owner) |

## Verification
The epoch tick can land in the same cycle as a fill or an access to the same line. The fill must win and load the full count, and the access must be judged on the count held before the tick. Directed steps drive a fill together with a tick, then count the ticks still needed before the owner is granted. A seeded random stream raises the tick on about one cycle in six, alongside mixed accesses, fills and evictions. Every response is compared against a bench model that applies the request rules before the aging.

// File: rtl/pld_pkg.sv
package pld_pkg;
    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_FILL   = 2'd1,
        OP_EVICT  = 2'd2,
        OP_NONE   = 2'd3
    } pld_op_e;
endpackage

// File: rtl/pld_line_slot.sv
module pld_line_slot
    import pld_pkg::*;
#(
    parameter int CORE_W   = 2,
    parameter int AGE_W    = 2,
    parameter int MAT_LOAD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              sel,
    input  pld_op_e           op,
    input  logic [CORE_W-1:0] core,
    output logic              grant,
    output logic              inv,
    output logic [CORE_W-1:0] owner
);
    typedef struct packed {
        logic              valid;
        logic              owned;
        logic [CORE_W-1:0] owner;
        logic              shared;
        logic              cached;
        logic [AGE_W-1:0]  age;
    } slot_t;

    slot_t st_d, st_q;
    logic  same_core;

    always_comb begin
        st_d      = st_q;
        grant     = 1'b0;
        inv       = 1'b0;
        same_core = !st_q.owned || (st_q.owner == core);
        if (tick && st_q.valid && (st_q.age != '0))
            st_d.age = st_q.age - 1'b1;
        if (sel) begin
            case (op)
                OP_FILL: begin
                    st_d        = '0;
                    st_d.valid  = 1'b1;
                    st_d.age    = AGE_W'(MAT_LOAD);
                end
                OP_EVICT: st_d = '0;
                OP_ACCESS: begin
                    if (st_q.valid) begin
                        if (!st_q.owned) begin
                            st_d.owned = 1'b1;
                            st_d.owner = core;
                        end
                        if (same_core) begin
                            if (!st_q.shared && (st_q.age == '0)) begin
                                grant       = 1'b1;
                                st_d.cached = 1'b1;
                            end
                        end else begin
                            st_d.shared = 1'b1;
                            if (st_q.cached) begin
                                inv         = 1'b1;
                                st_d.cached = 1'b0;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner = st_q.owner;

    // R5
    shared_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.shared && !(sel && (op == OP_FILL || op == OP_EVICT))) |=> st_q.shared);

    // R4
    grant_not_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.cached && st_q.shared));

    // R9
    fill_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_FILL) |=> (st_q.age == AGE_W'(MAT_LOAD)) && !st_q.owned);

    // R8
    evict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_EVICT) |=> (!st_q.valid && !st_q.shared && !st_q.cached && !st_q.owned));
endmodule

// File: rtl/pld_resp_reg.sv
module pld_resp_reg
    import pld_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int CORE_W    = 2,
    parameter int LINE_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  pld_op_e              op,
    input  logic [LINE_W-1:0]    line,
    input  logic [NUM_LINES-1:0] grant_vec,
    input  logic [NUM_LINES-1:0] inv_vec,
    input  logic [CORE_W-1:0]    owner_arr [NUM_LINES],
    output logic                 rsp_valid,
    output logic                 rsp_cacheable,
    output logic                 inv_valid,
    output logic [CORE_W-1:0]    inv_core
);
    typedef struct packed {
        logic              rsp;
        logic              ok;
        logic              inv;
        logic [CORE_W-1:0] who;
    } resp_t;

    resp_t r_d, r_q;

    always_comb begin
        r_d = '0;
        if (req_valid && op == OP_ACCESS) begin
            r_d.rsp = 1'b1;
            r_d.ok  = grant_vec[line];
            r_d.inv = inv_vec[line];
            if (inv_vec[line]) r_d.who = owner_arr[line];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid     = r_q.rsp;
    assign rsp_cacheable = r_q.ok;
    assign inv_valid     = r_q.inv;
    assign inv_core      = r_q.who;

    // R10
    inv_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(req_valid));

    // R6
    inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (rsp_valid && !rsp_cacheable));

    // R10
    ok_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cacheable |-> rsp_valid);
endmodule

// File: rtl/private_line_detector.sv
module private_line_detector
    import pld_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int NUM_LINES = 8,
    parameter int MAT_LOAD  = 2,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int AGE_W    = $clog2(MAT_LOAD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              epoch_tick,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [CORE_W-1:0] req_core,
    output logic              rsp_valid,
    output logic              rsp_cacheable,
    output logic              inv_valid,
    output logic [CORE_W-1:0] inv_core
);
    pld_op_e              op;
    logic [NUM_LINES-1:0] grant_vec;
    logic [NUM_LINES-1:0] inv_vec;
    logic [CORE_W-1:0]    owner_arr [NUM_LINES];

    assign op = pld_op_e'(req_op);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_slot
        logic sel;
        assign sel = req_valid && (req_line == LINE_W'(i));
        pld_line_slot #(
            .CORE_W  (CORE_W),
            .AGE_W   (AGE_W),
            .MAT_LOAD(MAT_LOAD)
        ) u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (epoch_tick),
            .sel  (sel),
            .op   (op),
            .core (req_core),
            .grant(grant_vec[i]),
            .inv  (inv_vec[i]),
            .owner(owner_arr[i])
        );
    end

    pld_resp_reg #(
        .NUM_LINES(NUM_LINES),
        .CORE_W   (CORE_W),
        .LINE_W   (LINE_W)
    ) u_resp (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .op           (op),
        .line         (req_line),
        .grant_vec    (grant_vec),
        .inv_vec      (inv_vec),
        .owner_arr    (owner_arr),
        .rsp_valid    (rsp_valid),
        .rsp_cacheable(rsp_cacheable),
        .inv_valid    (inv_valid),
        .inv_core     (inv_core)
    );

    // R6
    single_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(inv_vec) && $onehot0(grant_vec));
endmodule

// File: tb/private_line_detector_tb.sv
`timescale 1ns/1ps
module private_line_detector_tb;
    localparam int NC = 4;
    localparam int NL = 8;
    localparam int ML = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       epoch_tick = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd3;
    logic [2:0] req_line = '0;
    logic [1:0] req_core = '0;
    logic       rsp_valid, rsp_cacheable, inv_valid;
    logic [1:0] inv_core;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit m_valid [NL];
    bit m_owned [NL];
    int m_owner [NL];
    bit m_np    [NL];
    bit m_cached[NL];
    int m_age   [NL];

    always #2 clk = ~clk;

    private_line_detector #(.NUM_CORES(NC), .NUM_LINES(NL), .MAT_LOAD(ML)) u_dut (
        .clk(clk), .rst_n(rst_n), .epoch_tick(epoch_tick),
        .req_valid(req_valid), .req_op(req_op), .req_line(req_line), .req_core(req_core),
        .rsp_valid(rsp_valid), .rsp_cacheable(rsp_cacheable),
        .inv_valid(inv_valid), .inv_core(inv_core)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit v, int op, int line, int core, bit tk, string tag);
        bit e_rv, e_c, e_inv, same;
        int e_ic;
        e_rv = v && (op == 0);
        e_c = 0; e_inv = 0; e_ic = 0; same = 0;
        if (v && op == 0 && m_valid[line]) begin
            same = !m_owned[line] || (m_owner[line] == core);
            if (same) e_c = !m_np[line] && (m_age[line] == 0);
            else if (m_cached[line]) begin e_inv = 1; e_ic = m_owner[line]; end
        end
        if (tk) for (int i = 0; i < NL; i++) if (m_valid[i] && m_age[i] > 0) m_age[i]--;
        if (v) begin
            case (op)
                0: if (m_valid[line]) begin
                    if (!m_owned[line]) begin m_owned[line] = 1; m_owner[line] = core; end
                    if (same && e_c) m_cached[line] = 1;
                    if (!same) begin m_np[line] = 1; m_cached[line] = 0; end
                end
                1: begin
                    m_valid[line] = 1; m_owned[line] = 0; m_owner[line] = 0;
                    m_np[line] = 0; m_cached[line] = 0; m_age[line] = ML;
                end
                2: begin
                    m_valid[line] = 0; m_owned[line] = 0; m_owner[line] = 0;
                    m_np[line] = 0; m_cached[line] = 0; m_age[line] = 0;
                end
                default: ;
            endcase
        end
        req_valid = v; req_op = 2'(op); req_line = 3'(line); req_core = 2'(core);
        epoch_tick = tk;
        @(negedge clk);
        chk(rsp_valid == e_rv, tag, "rsp_valid", rsp_valid, e_rv);
        chk(rsp_cacheable == e_c, tag, "rsp_cacheable", rsp_cacheable, e_c);
        chk(inv_valid == e_inv, tag, "inv_valid", inv_valid, e_inv);
        if (e_inv) chk(inv_core == 2'(e_ic), tag, "inv_core", int'(inv_core), e_ic);
        req_valid = 0; req_op = 2'd3; epoch_tick = 0;
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin
            m_valid[i] = 0; m_owned[i] = 0; m_owner[i] = 0;
            m_np[i] = 0; m_cached[i] = 0; m_age[i] = 0;
        end
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !rsp_cacheable && !inv_valid, "R1", "outputs in reset", int'(rsp_valid | inv_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(!rsp_valid && !rsp_cacheable && !inv_valid, "R1", "outputs after reset", int'(rsp_valid | inv_valid), 0);

        // R2: access to absent line, then fresh owner after fill
        step(1, 0, 3, 1, 0, "R2");
        step(1, 1, 3, 0, 0, "R2");
        step(0, 0, 0, 0, 1, "R2");
        step(0, 0, 0, 0, 1, "R2");
        step(1, 0, 3, 2, 0, "R2");
        // R3 / R4: maturity and owner recording
        step(1, 1, 5, 0, 0, "R10");
        step(1, 0, 5, 1, 0, "R3");
        step(0, 0, 0, 0, 1, "R4");
        step(1, 0, 5, 1, 0, "R4");
        step(0, 0, 0, 0, 1, "R4");
        step(1, 0, 5, 1, 0, "R4");
        step(1, 0, 5, 1, 0, "R3");
        step(0, 0, 0, 0, 0, "R10");
        // R6: second core on granted line
        step(1, 0, 5, 0, 0, "R6");
        step(1, 0, 5, 1, 0, "R5");
        step(0, 0, 0, 0, 1, "R5");
        step(1, 0, 5, 1, 0, "R5");
        // R7: sharing without a granted copy
        step(1, 1, 7, 0, 0, "R7");
        step(1, 0, 7, 2, 0, "R7");
        step(1, 0, 7, 3, 0, "R7");
        step(0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 1, "R7");
        step(1, 0, 7, 2, 0, "R5");
        // R8: eviction resets the record
        step(1, 2, 5, 0, 0, "R10");
        step(1, 0, 5, 3, 0, "R8");
        step(1, 1, 5, 0, 0, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(0, 0, 0, 0, 1, "R8");
        step(1, 0, 5, 3, 0, "R8");
        // R9: fill coincident with tick, access coincident with tick
        step(1, 1, 1, 0, 1, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(1, 0, 1, 2, 1, "R9");
        step(1, 0, 1, 2, 0, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(1, 0, 1, 2, 0, "R9");

        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 10;
            step(r < 8, (r < 6) ? 0 : (r == 6) ? 1 : 2, $urandom % NL, $urandom % NC,
                 ($urandom % 6) == 0, "R4");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule